// File: doc/BRIEF.md
# RMII to MII Receive Converter

This block takes the receive side of a reduced-pin Ethernet PHY link and presents it as a four-bit MII receive interface to a MAC. The PHY delivers two-bit dibits on a 50 MHz reference clock, along with one line that carries both carrier-sense and data-valid. The block discards line noise that comes before the preamble. It locks nibble alignment onto the first `01` preamble dibit and then joins each pair of dibits into one nibble. Preamble and start-of-frame nibbles are passed through unchanged, so the MAC sees a run of `0x5` nibbles closed by `0xD`.

The receive clock for the MAC is derived from the reference clock. It is divided by 2 for 100 Mbps and by 20 for 10 Mbps. Every output changes on the rising edge of that clock, so the MAC can sample on the falling edge. At the end of a frame the PHY may toggle the combined line once per nibble while it drains buffered data. The block keeps data-valid high through that tail. It closes the frame only when the line is low for both dibits of a nibble.

Top module: `rmii_to_mii_rx`

## Requirements
- R1: While reset is low, `mii_rx_dv`, `mii_rx_er`, `mii_rx_clk` are 0 and `mii_rxd` is 0000.
- R2: `mii_rx_clk` runs continuously after reset with a period of 2 reference cycles when `rate_10m`=0, and 20 cycles when `rate_10m`=1.
- R3: `mii_rx_dv`, `mii_rxd` and `mii_rx_er` change only on the reference edge at which `mii_rx_clk` goes from 0 to 1.
- R4: After `crs_dv` rises, dibits other than `01` (values 00, 10, 11) are discarded and produce no nibble. `crs_dv` falling before a `01` arrives returns the block to idle without any output.
- R5: The first `01` dibit fixes the alignment. The first dibit of each pair becomes bits [1:0] of the nibble and the second becomes bits [3:2]. The preamble therefore appears as 0x5 and the `01`,`11` delimiter as 0xD.
- R6: A nibble whose two dibits both arrive with `crs_dv`=0 ends the frame. That nibble is dropped and `mii_rx_dv` falls after the last delivered nibble. A new frame starts only on a later 0-to-1 transition of `crs_dv`, and a carrier already high at reset is ignored.
- R7: A nibble with `crs_dv`=0 on its first dibit and 1 on its second is delivered as data, and `mii_rx_dv` stays high.
- R8: A nibble with `crs_dv`=1 on its first dibit and 0 on its second is delivered with `mii_rx_er`=1.
- R9: Whenever `mii_rx_dv` is 0, `mii_rxd` is 0000 and `mii_rx_er` is 0.
- R10: With `rate_10m`=1 the line is sampled once per 10 reference cycles. Dibits held for 10 cycles each are all delivered exactly once.
- R11: Every delivered nibble appears exactly once, in arrival order, on one `mii_rx_clk` rising edge with `mii_rx_dv`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_10m | input | 1 | 1 selects 10 Mbps, 0 selects 100 Mbps |
| crs_dv | input | 1 | Combined carrier-sense / data-valid from the PHY |
| rxd | input | 2 | Receive dibit from the PHY |
| mii_rx_clk | output | 1 | Derived MII receive clock (25 MHz or 2.5 MHz) |
| mii_rx_dv | output | 1 | MII receive data valid |
| mii_rxd | output | 4 | MII receive nibble |
| mii_rx_er | output | 1 | Nibble received while carrier dropped mid-nibble |

## Verification
Two things can land on the same sampling tick: a nibble finishing assembly and the output stage loading on a `mii_rx_clk` rise. Which one wins depends on the parity of the leading junk dibits. The bench runs frames with odd and even lead-in counts, so that both cases occur. It also places the frame-ending nibble against either phase of the clock. A scoreboard queue holds every nibble in order and compares each one at the next clock rise. A nibble lost or repeated when the two events coincide shows up as a mismatch, or as a non-empty queue after the frame.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  parameter int DIBIT_W = 2;
  parameter int NIB_W   = 2 * DIBIT_W;
  parameter logic [DIBIT_W-1:0] PRE_DIBIT = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } align_st_t;

  // earlier dibit lands in the low half of the nibble
  function automatic logic [NIB_W-1:0] pack_nibble(input logic [DIBIT_W-1:0] first,
                                                   input logic [DIBIT_W-1:0] second);
    return {second, first};
  endfunction

  // wrap counter for the slow-rate sampling divider
  function automatic int next_count(input int cnt, input int div);
    return (cnt >= div - 1) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/rx_rate_tick.sv
module rx_rate_tick #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_10m,
  output logic tick,
  output logic load,
  output logic mii_clk
);
  import rmii_rx_pkg::*;

  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          half;

  always_comb begin
    tick    = rate_10m ? (cnt == '0) : 1'b1;
    load    = tick && !half;
    mii_clk = half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      cnt <= rate_10m ? CW'(next_count(int'(cnt), SLOW_DIV)) : '0;
      if (tick) half <= !half;
    end
  end

  // R2: at the slow rate two sampling ticks are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate_10m) |=> (!tick || !rate_10m));

endmodule

// File: rtl/rx_dibit_align.sv
module rx_dibit_align
  import rmii_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               crs_dv,
  input  logic [DIBIT_W-1:0] rxd,
  output logic               nib_done,
  output logic [NIB_W-1:0]   nib_data,
  output logic               nib_err,
  output logic               frame_end
);

  align_st_t          st;
  logic               crs_q;
  logic               have_lo;
  logic               lo_crs;
  logic [DIBIT_W-1:0] lo_d;

  logic crs_rise, pre_hit, second_half;

  always_comb begin
    crs_rise    = crs_dv && !crs_q;
    pre_hit     = (rxd == PRE_DIBIT);
    second_half = tick && (st == ST_DATA) && have_lo;
    nib_done    = second_half && (lo_crs || crs_dv);
    frame_end   = second_half && !lo_crs && !crs_dv;
    nib_data    = pack_nibble(lo_d, rxd);
    nib_err     = lo_crs && !crs_dv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      crs_q   <= 1'b1;   // a carrier already present is not a rising edge
      have_lo <= 1'b0;
      lo_crs  <= 1'b0;
      lo_d    <= '0;
    end else if (tick) begin
      crs_q <= crs_dv;
      unique case (st)
        ST_IDLE: if (crs_rise) begin
          if (pre_hit) begin
            st      <= ST_DATA;
            have_lo <= 1'b1;
            lo_d    <= rxd;
            lo_crs  <= 1'b1;
          end else begin
            st <= ST_HUNT;
          end
        end
        ST_HUNT: if (!crs_dv) begin
          st <= ST_IDLE;
        end else if (pre_hit) begin
          st      <= ST_DATA;
          have_lo <= 1'b1;
          lo_d    <= rxd;
          lo_crs  <= 1'b1;
        end
        ST_DATA: if (!have_lo) begin
          lo_d    <= rxd;
          lo_crs  <= crs_dv;
          have_lo <= 1'b1;
        end else begin
          have_lo <= 1'b0;
          if (!lo_crs && !crs_dv) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: alignment is only ever taken on a preamble dibit
  a_r5_align_on_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_DATA) |-> $past(tick && rxd == PRE_DIBIT));

  // R6: nothing is produced on the tick after a frame closes
  a_r6_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !nib_done);

endmodule

// File: rtl/rx_mii_out.sv
module rx_mii_out
  import rmii_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mii_clk,
  input  logic             nib_done,
  input  logic [NIB_W-1:0] nib_data,
  input  logic             nib_err,
  output logic             dv,
  output logic [NIB_W-1:0] d,
  output logic             er
);

  logic             pend_full;
  logic [NIB_W-1:0] pend_d;
  logic             pend_er;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_d    <= '0;
      pend_er   <= 1'b0;
      dv        <= 1'b0;
      d         <= '0;
      er        <= 1'b0;
    end else begin
      // the output stage takes the old pending nibble before it is replaced
      if (load) begin
        dv <= pend_full;
        d  <= pend_full ? pend_d : '0;
        er <= pend_full && pend_er;
      end
      if (nib_done) begin
        pend_full <= 1'b1;
        pend_d    <= nib_data;
        pend_er   <= nib_err;
      end else if (load) begin
        pend_full <= 1'b0;
      end
    end
  end

  // R3: outputs move only together with a rising receive clock
  a_r3_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(d) || !$stable(dv) || !$stable(er)) |-> $rose(mii_clk));

  // R9: idle nibble is all zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dv |-> (d == '0 && !er));

  // R11: a pending nibble is never overwritten before it is shown
  a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_done && pend_full) |-> load);

endmodule

// File: rtl/rmii_to_mii_rx.sv
module rmii_to_mii_rx
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               rate_10m,
  input  logic               crs_dv,
  input  logic [DIBIT_W-1:0] rxd,
  output logic               mii_rx_clk,
  output logic               mii_rx_dv,
  output logic [NIB_W-1:0]   mii_rxd,
  output logic               mii_rx_er
);

  logic             tick, load;
  logic             nib_done, nib_err, frame_end;
  logic [NIB_W-1:0] nib_data;

  rx_rate_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .rate_10m (rate_10m),
    .tick     (tick),
    .load     (load),
    .mii_clk  (mii_rx_clk)
  );

  rx_dibit_align u_align (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .crs_dv    (crs_dv),
    .rxd       (rxd),
    .nib_done  (nib_done),
    .nib_data  (nib_data),
    .nib_err   (nib_err),
    .frame_end (frame_end)
  );

  rx_mii_out u_out (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .load     (load),
    .mii_clk  (mii_rx_clk),
    .nib_done (nib_done),
    .nib_data (nib_data),
    .nib_err  (nib_err),
    .dv       (mii_rx_dv),
    .d        (mii_rxd),
    .er       (mii_rx_er)
  );

  // R6: a frame close and a nibble delivery are exclusive on a tick
  a_r6_end_excludes_nibble: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(frame_end && nib_done));

endmodule

// File: tb/tb_rmii_to_mii_rx.sv
module tb_rmii_to_mii_rx;

  localparam int CLK_PERIOD = 20;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_10m = 1'b0;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       mii_rx_clk, mii_rx_dv, mii_rx_er;
  logic [3:0] mii_rxd;

  int checks = 0;
  int errors = 0;
  int hold = 1;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  rmii_to_mii_rx dut (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .rate_10m   (rate_10m),
    .crs_dv     (crs_dv),
    .rxd        (rxd),
    .mii_rx_clk (mii_rx_clk),
    .mii_rx_dv  (mii_rx_dv),
    .mii_rxd    (mii_rxd),
    .mii_rx_er  (mii_rx_er)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitor: pops the scoreboard at every clock rise
  logic prev_clk, prev_dv, prev_er;
  logic [3:0] prev_d;
  bit   have_period;
  int   cyc;

  always @(negedge ref_clk) begin
    if (!rst_n) begin
      have_period = 0;
      cyc = 0;
    end else begin
      cyc++;
      if (mii_rx_clk && !prev_clk) begin
        if (have_period)
          chk(cyc == (rate_10m ? 20 : 2), "R2", "clock period", cyc, rate_10m ? 20 : 2);
        have_period = 1;
        cyc = 0;
        if (mii_rx_dv) begin
          if (exp_q.size() == 0) begin
            chk(0, "R4", "unexpected nibble", int'(mii_rxd), 0);
          end else begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({mii_rx_er, mii_rxd} == e, t, "nibble {er,d}", int'({mii_rx_er, mii_rxd}), int'(e));
          end
        end else begin
          chk(mii_rxd == 4'd0 && !mii_rx_er, "R9", "idle nibble", int'({mii_rx_er, mii_rxd}), 0);
        end
      end else begin
        chk(mii_rx_dv == prev_dv && mii_rxd == prev_d && mii_rx_er == prev_er, "R3",
            "output moved off clock rise", int'({mii_rx_dv, mii_rx_er, mii_rxd}),
            int'({prev_dv, prev_er, prev_d}));
      end
    end
    prev_clk = mii_rx_clk;
    prev_dv  = mii_rx_dv;
    prev_d   = mii_rxd;
    prev_er  = mii_rx_er;
  end

  // ---------------- driver
  task automatic put_dibit(input logic c, input logic [1:0] d);
    crs_dv = c;
    rxd    = d;
    repeat (hold) @(negedge ref_clk);
  endtask

  task automatic push_exp(input logic er, input logic [3:0] nib, input string tag);
    exp_q.push_back({er, nib});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input logic slow, input logic crs_at_reset);
    @(negedge ref_clk);
    rst_n    = 1'b0;
    rate_10m = slow;
    hold     = slow ? 10 : 1;
    crs_dv   = crs_at_reset;
    rxd      = crs_at_reset ? 2'b01 : 2'b00;
    repeat (4) @(negedge ref_clk);
    chk(!mii_rx_dv && !mii_rx_er && mii_rxd == 4'd0 && !mii_rx_clk, "R1", "reset outputs",
        int'({mii_rx_clk, mii_rx_dv, mii_rx_er, mii_rxd}), 0);
    rst_n = 1'b1;
  endtask

  task automatic drain_and_check(input string what);
    repeat (hold * 8) @(negedge ref_clk);
    chk(exp_q.size() == 0, "R6", {what, ": nibbles left"}, exp_q.size(), 0);
    chk(!mii_rx_dv, "R6", {what, ": dv after end"}, int'(mii_rx_dv), 0);
  endtask

  // lead junk dibits, preamble, data with optional toggle tail and one error nibble
  task automatic send_frame(input int nlead, input bit mix, input int ndata,
                            input int tog_tail, input int err_at);
    string dtag;
    dtag = (hold == 10) ? "R10" : "R11";
    for (int i = 0; i < nlead; i++) put_dibit(1'b1, (mix && i == 1) ? 2'b10 : 2'b00);
    for (int i = 0; i < 15; i++) begin
      push_exp(1'b0, 4'h5, "R5");
      put_dibit(1'b1, 2'b01);
      put_dibit(1'b1, 2'b01);
    end
    push_exp(1'b0, 4'hD, "R5");
    put_dibit(1'b1, 2'b01);
    put_dibit(1'b1, 2'b11);
    for (int i = 0; i < ndata; i++) begin
      logic [3:0] nib;
      logic c0, c1;
      string tg;
      nib = 4'($urandom);
      c0 = 1'b1;
      c1 = 1'b1;
      tg = dtag;
      if (i >= ndata - tog_tail) begin c0 = 1'b0; tg = "R7"; end
      if (i == err_at)           begin c0 = 1'b1; c1 = 1'b0; tg = "R8"; end
      push_exp(c0 && !c1, nib, tg);
      put_dibit(c0, nib[1:0]);
      put_dibit(c1, nib[3:2]);
    end
    put_dibit(1'b0, 2'b00);
    put_dibit(1'b0, 2'b00);
  endtask

  initial begin
    // R1 reset, then 100 Mbps frames
    do_reset(1'b0, 1'b0);
    repeat (6) @(negedge ref_clk);
    send_frame(3, 0, 128, 0, -1);
    drain_and_check("plain frame odd lead");
    send_frame(4, 0, 40, 6, 10);
    drain_and_check("toggle tail even lead");
    send_frame(5, 1, 20, 0, 0);
    drain_and_check("mixed junk lead R4");
    // back-to-back: carrier rises straight onto a preamble dibit
    send_frame(0, 0, 16, 3, 15);
    send_frame(0, 0, 16, 0, -1);
    drain_and_check("back to back");

    // R4 false carrier: junk only, then carrier drops
    for (int i = 0; i < 5; i++) put_dibit(1'b1, 2'b00);
    for (int i = 0; i < 3; i++) put_dibit(1'b0, 2'b00);
    drain_and_check("false carrier R4");

    // R6 carrier already high at reset is ignored until it drops
    do_reset(1'b0, 1'b1);
    repeat (12) put_dibit(1'b1, 2'b01);
    put_dibit(1'b0, 2'b00);
    drain_and_check("carrier held over reset");
    send_frame(2, 0, 10, 0, -1);
    drain_and_check("frame after held carrier");

    // R10 slow rate
    do_reset(1'b1, 1'b0);
    repeat (30) @(negedge ref_clk);
    send_frame(2, 0, 12, 2, 5);
    drain_and_check("slow frame");
    send_frame(1, 1, 6, 0, -1);
    drain_and_check("slow frame odd lead");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule